// File: doc/BRIEF.md
# BCD Clock-Calendar Counter

This block holds a running time of day and calendar date as seven BCD registers: seconds, minutes, hours, day of week, day of month, month (with a century flag in its top bit) and year. A free-running enable, nominally at 32.768 kHz, drives a prescaler. Each time the prescaler completes a full count, the seconds register advances by one, and carries ripple up through minutes, hours, day, date, month and year. Hours are kept in 24-hour or 12-hour form. In 12-hour form the hours register also carries an afternoon flag. The month-end is corrected for short months and for leap-year February.

A host writes any register through a one-cycle write strobe with a register code and a data byte. All seven registers are visible at all times on parallel outputs. Writing the seconds register also restarts the prescaler. The 1 Hz square-wave output is derived from the prescaler phase, so it lines up with that write.

Top module: `bcd_clock_calendar`

## Requirements
- R1: Seconds advance by one BCD step after every DIVIDE cycles with `tick_en` high. Seconds 59 wrap to 00 and advance minutes, and minutes 59 wrap to 00 and advance hours.
- R2: When hours bit 6 is 0 (24-hour form), hours count 00..23 in BCD with bit 5 as the tens-of-twenty digit. Hour 23 wraps to 00 and starts a new day.
- R3: When hours bit 6 is 1 (12-hour form), bits 4:0 hold 01..12 in BCD and bit 5 is 1 for afternoon. The hour sequence is 12, 01, …, 11. The afternoon flag toggles on 11→12. Afternoon 11 moving to 12 starts a new day.
- R4: On a new day, the date wraps to 01 and the month advances after the last day of the month. The last day is 30 for months 04, 06, 09 and 11, and 31 for the other months. For February it is 29 when the BCD year is divisible by 4, and 28 otherwise.
- R5: Month 12 wraps to 01 and advances the year. Year 99 wraps to 00 and toggles the century flag in month bit 7.
- R6: The day of week advances on each new day and wraps from 7 to 1.
- R7: A write with `wr_en` high loads the register chosen by `wr_addr`: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year. Code 7 changes nothing. A write overrides a count step of the same register in that cycle and produces no carry from it.
- R8: Bits that are defined as 0 read back 0 after any write. The kept-bit masks are seconds 7F, minutes 7F, hours 7F, day of week 07, date 3F, month 9F and year FF.
- R9: A seconds write restarts the prescaler and drives `sq_1hz` low. `sq_1hz` rises after DIVIDE/2 further ticks. The next seconds step comes DIVIDE ticks after the write, and `sq_1hz` falls at that step.
- R10: After reset the registers read seconds 00, minutes 00, hours 00 (24-hour form), day of week 1, date 01, month 01 with the century flag clear, and year 00, with `sq_1hz` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Prescaler enable, one pulse per oscillator period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register code for the write |
| wr_data | input | 8 | Write data byte |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hours with mode and afternoon bits |
| dow_o | output | 8 | Day of week 1..7 |
| date_o | output | 8 | Day of month, BCD |
| month_o | output | 8 | Month, BCD, with century flag in bit 7 |
| year_o | output | 8 | Year, BCD |
| sq_1hz | output | 1 | Square wave at the seconds rate |

## Verification
The bench builds the block with DIVIDE set to 4. At that value a full second is four enabled cycles and the half-second point is two. This makes the square-wave phase, the prescaler restart and every calendar rollover reachable in a few dozen cycles. Those rollovers cover the year and century wrap, leap and common Februaries, the 30-day months and the 12-hour midnight. The value 4 is a power of two, so the free-running prescaler variant is the one selected.

// File: rtl/bcdcal_pkg.sv
package bcdcal_pkg;

   localparam logic [2:0] REG_SEC  = 3'd0;
   localparam logic [2:0] REG_MIN  = 3'd1;
   localparam logic [2:0] REG_HOUR = 3'd2;
   localparam logic [2:0] REG_DOW  = 3'd3;
   localparam logic [2:0] REG_DATE = 3'd4;
   localparam logic [2:0] REG_MON  = 3'd5;
   localparam logic [2:0] REG_YEAR = 3'd6;

   localparam logic [7:0] KEEP_SEC  = 8'h7F;
   localparam logic [7:0] KEEP_MIN  = 8'h7F;
   localparam logic [7:0] KEEP_HOUR = 8'h7F;
   localparam logic [7:0] KEEP_DOW  = 8'h07;
   localparam logic [7:0] KEEP_DATE = 8'h3F;
   localparam logic [7:0] KEEP_MON  = 8'h9F;
   localparam logic [7:0] KEEP_YEAR = 8'hFF;

   // Next value of a two-digit BCD number (no range check)
   function automatic logic [7:0] bcd_inc(input logic [7:0] v);
      logic [7:0] r;
      if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
      else                r = {v[7:4], v[3:0] + 4'd1};
      return r;
   endfunction

   // Last day of a month in BCD; every year divisible by 4 is a leap year
   function automatic logic [7:0] last_day(input logic [4:0] mon, input logic [7:0] yr);
      logic [7:0] bin;
      logic [7:0] r;
      bin = ({4'd0, yr[7:4]} * 8'd10) + {4'd0, yr[3:0]};
      case (mon)
         5'h02:                      r = (bin[1:0] == 2'b00) ? 8'h29 : 8'h28;
         5'h04, 5'h06, 5'h09, 5'h11: r = 8'h30;
         default:                    r = 8'h31;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/bcdcal_prescaler.sv
module bcdcal_prescaler #(
   parameter int DIVIDE = 32768
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_en,
   input  logic restart,
   output logic sec_step,
   output logic sq_1hz
);
   localparam int         W      = (DIVIDE > 2) ? $clog2(DIVIDE) : 1;
   localparam logic [W-1:0] LAST = W'(DIVIDE - 1);
   localparam logic [W-1:0] HALF = W'(DIVIDE / 2);
   localparam bit         POW2   = ((DIVIDE & (DIVIDE - 1)) == 0);

   logic [W-1:0] phase;

   if (DIVIDE < 2) begin : g_bad_divide
      $error("bcdcal_prescaler: DIVIDE must be at least 2");
   end

   if (POW2) begin : g_free_run
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       phase <= '0;
         else if (restart) phase <= '0;
         else if (tick_en) phase <= phase + 1'b1;
      end
   end else begin : g_compare
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       phase <= '0;
         else if (restart) phase <= '0;
         else if (tick_en) phase <= (phase == LAST) ? '0 : phase + 1'b1;
      end
   end

   assign sec_step = tick_en && !restart && (phase == LAST);
   assign sq_1hz   = (phase >= HALF);

   // R9: a restart leaves the square wave low on the next cycle
   a_r9_restart_low: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !sq_1hz);
   // R9: the square wave falls exactly when a second step is issued
   a_r9_fall_on_step: assert property (@(posedge clk) disable iff (!rst_n)
      sec_step |=> !sq_1hz);
endmodule

// File: rtl/bcdcal_wrap.sv
module bcdcal_wrap
   import bcdcal_pkg::*;
#(
   parameter logic [7:0] LO   = 8'h00,
   parameter logic [7:0] HI   = 8'h59,
   parameter logic [7:0] KEEP = 8'h7F
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       step,
   input  logic       wr,
   input  logic [7:0] wdata,
   output logic [7:0] q,
   output logic       carry
);
   if (LO > HI) begin : g_bad_range
      $error("bcdcal_wrap: LO above HI");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= LO;
      else if (wr)   q <= wdata & KEEP;
      else if (step) q <= (q == HI) ? LO : bcd_inc(q);
   end

   assign carry = step && !wr && (q == HI);

   // R1: a step at the top value returns the field to its base value
   a_r1_wrap_to_base: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !wr && q == HI) |=> (q == LO));
   // R7: a write always lands, masked, regardless of a concurrent step
   a_r7_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (q == ($past(wdata) & KEEP)));
endmodule

// File: rtl/bcdcal_hours.sv
module bcdcal_hours
   import bcdcal_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       step,
   input  logic       wr,
   input  logic [7:0] wdata,
   output logic [7:0] q,
   output logic       day_step
);
   logic [7:0] nxt;
   logic       new_day;
   logic [7:0] inc12;
   logic [7:0] inc24;

   assign inc12 = bcd_inc({3'b000, q[4:0]});
   assign inc24 = bcd_inc({2'b00, q[5:0]});

   always_comb begin
      nxt     = q;
      new_day = 1'b0;
      if (q[6]) begin
         case (q[4:0])
            5'h12:   nxt = {q[7:5], 5'h01};
            5'h11: begin
               nxt     = {q[7:6], ~q[5], 5'h12};
               new_day = q[5];
            end
            default: nxt = {q[7:5], inc12[4:0]};
         endcase
      end else begin
         if (q[5:0] == 6'h23) begin
            nxt     = {q[7:6], 6'h00};
            new_day = 1'b1;
         end else begin
            nxt = {q[7:6], inc24[5:0]};
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= 8'h00;
      else if (wr)   q <= wdata & KEEP_HOUR;
      else if (step) q <= nxt;
   end

   assign day_step = step && !wr && new_day;

   // R3: in 12-hour form the 11 to 12 step flips the afternoon flag
   a_r3_pm_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !wr && q[6] && q[4:0] == 5'h11) |=> (q[5] != $past(q[5])));
   // R2: counting never changes the 12/24 mode bit
   a_r2_mode_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !wr) |=> $stable(q[6]));
endmodule

// File: rtl/bcd_clock_calendar.sv
module bcd_clock_calendar
   import bcdcal_pkg::*;
#(
   parameter int DIVIDE = 32768
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_en,
   input  logic       wr_en,
   input  logic [2:0] wr_addr,
   input  logic [7:0] wr_data,
   output logic [7:0] sec_o,
   output logic [7:0] min_o,
   output logic [7:0] hour_o,
   output logic [7:0] dow_o,
   output logic [7:0] date_o,
   output logic [7:0] month_o,
   output logic [7:0] year_o,
   output logic       sq_1hz
);
   logic wr_sec, wr_min, wr_hour, wr_dow, wr_date, wr_mon, wr_year;
   logic sec_step, sec_carry, min_carry, day_step, year_carry;
   logic month_step, year_step;
   logic [7:0] sec_q, min_q, hour_q, dow_q, date_q, mon_q, year_q;
   logic [7:0] month_last;

   assign wr_sec  = wr_en && (wr_addr == REG_SEC);
   assign wr_min  = wr_en && (wr_addr == REG_MIN);
   assign wr_hour = wr_en && (wr_addr == REG_HOUR);
   assign wr_dow  = wr_en && (wr_addr == REG_DOW);
   assign wr_date = wr_en && (wr_addr == REG_DATE);
   assign wr_mon  = wr_en && (wr_addr == REG_MON);
   assign wr_year = wr_en && (wr_addr == REG_YEAR);

   bcdcal_prescaler #(.DIVIDE(DIVIDE)) u_pre (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .restart(wr_sec),
      .sec_step(sec_step), .sq_1hz(sq_1hz));

   bcdcal_wrap #(.LO(8'h00), .HI(8'h59), .KEEP(KEEP_SEC)) u_sec (
      .clk(clk), .rst_n(rst_n), .step(sec_step), .wr(wr_sec), .wdata(wr_data),
      .q(sec_q), .carry(sec_carry));

   bcdcal_wrap #(.LO(8'h00), .HI(8'h59), .KEEP(KEEP_MIN)) u_min (
      .clk(clk), .rst_n(rst_n), .step(sec_carry), .wr(wr_min), .wdata(wr_data),
      .q(min_q), .carry(min_carry));

   bcdcal_hours u_hour (
      .clk(clk), .rst_n(rst_n), .step(min_carry), .wr(wr_hour), .wdata(wr_data),
      .q(hour_q), .day_step(day_step));

   // Day of week: 1..7, advances once per new day
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        dow_q <= 8'h01;
      else if (wr_dow)   dow_q <= wr_data & KEEP_DOW;
      else if (day_step) dow_q <= (dow_q == 8'h07) ? 8'h01 : dow_q + 8'h01;
   end

   // Day of month with month-length correction
   assign month_last = last_day(mon_q[4:0], year_q);
   assign month_step = day_step && !wr_date && (date_q == month_last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        date_q <= 8'h01;
      else if (wr_date)  date_q <= wr_data & KEEP_DATE;
      else if (day_step) date_q <= (date_q == month_last) ? 8'h01 : bcd_inc(date_q);
   end

   // Month with century flag in bit 7
   assign year_step = month_step && !wr_mon && (mon_q[4:0] == 5'h12);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          mon_q <= 8'h01;
      else if (wr_mon)     mon_q <= wr_data & KEEP_MON;
      else if (month_step) begin
         mon_q[7]   <= mon_q[7] ^ year_carry;
         mon_q[6:0] <= (mon_q[4:0] == 5'h12) ? 7'h01 : bcd_inc({1'b0, mon_q[6:0]})[6:0];
      end
   end

   bcdcal_wrap #(.LO(8'h00), .HI(8'h99), .KEEP(KEEP_YEAR)) u_year (
      .clk(clk), .rst_n(rst_n), .step(year_step), .wr(wr_year), .wdata(wr_data),
      .q(year_q), .carry(year_carry));

   assign sec_o   = sec_q;
   assign min_o   = min_q;
   assign hour_o  = hour_q;
   assign dow_o   = dow_q;
   assign date_o  = date_q;
   assign month_o = mon_q;
   assign year_o  = year_q;

   // R6: day of week wraps from 7 to 1 at a new day
   a_r6_dow_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (day_step && !wr_dow && dow_q == 8'h07) |=> (dow_q == 8'h01));
   // R4: the last day of a month is followed by day 01
   a_r4_month_end: assert property (@(posedge clk) disable iff (!rst_n)
      (day_step && !wr_date && date_q == month_last) |=> (date_q == 8'h01));
   // R5: a year wrap flips the century flag
   a_r5_century: assert property (@(posedge clk) disable iff (!rst_n)
      (year_carry && !wr_mon) |=> (mon_q[7] != $past(mon_q[7])));
   // R7: write code 7 leaves every register unchanged when no count occurs
   a_r7_code7_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 3'd7 && !tick_en) |=>
         ($stable(sec_q) && $stable(min_q) && $stable(hour_q) && $stable(dow_q)
          && $stable(date_q) && $stable(mon_q) && $stable(year_q)));
endmodule

// File: tb/bcd_clock_calendar_test.sv
module bcd_clock_calendar_test;
   localparam int DIV = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = 3'd0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o;
   logic       sq_1hz;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      int         sel;
      logic [7:0] exp;
      string      tag;
   } item_t;

   item_t sbq[$];
   event  push_ev;

   always #5 clk = ~clk;

   bcd_clock_calendar #(.DIVIDE(DIV)) uut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .sec_o(sec_o), .min_o(min_o),
      .hour_o(hour_o), .dow_o(dow_o), .date_o(date_o), .month_o(month_o),
      .year_o(year_o), .sq_1hz(sq_1hz));

   function automatic logic [7:0] read_sel(input int sel);
      case (sel)
         0: return sec_o;
         1: return min_o;
         2: return hour_o;
         3: return dow_o;
         4: return date_o;
         5: return month_o;
         6: return year_o;
         default: return {7'd0, sq_1hz};
      endcase
   endfunction

   // Monitor: pops expected items and compares with the outputs
   initial begin
      forever begin
         @(push_ev);
         while (sbq.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it  = sbq.pop_front();
            act = read_sel(it.sel);
            checks++;
            if (act !== it.exp) begin
               errors++;
               $display("FAIL %s sel=%0d actual=%h expected=%h", it.tag, it.sel, act, it.exp);
            end
         end
      end
   end

   task automatic expect_reg(input int sel, input logic [7:0] e, input string tag);
      sbq.push_back('{sel, e, tag});
      ->push_ev;
   endtask

   task automatic write_reg(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic run_ticks(input int n);
      tick_en = 1'b1;
      repeat (n) @(negedge clk);
      tick_en = 1'b0;
   endtask

   task automatic set_all(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                          input logic [7:0] dw, input logic [7:0] dt, input logic [7:0] mo,
                          input logic [7:0] y);
      write_reg(3'd1, m);
      write_reg(3'd2, h);
      write_reg(3'd3, dw);
      write_reg(3'd4, dt);
      write_reg(3'd5, mo);
      write_reg(3'd6, y);
      write_reg(3'd0, s);
   endtask

   task automatic report;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         report();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R10: reset state
      expect_reg(0, 8'h00, "R10 seconds");
      expect_reg(1, 8'h00, "R10 minutes");
      expect_reg(2, 8'h00, "R10 hours");
      expect_reg(3, 8'h01, "R10 dow");
      expect_reg(4, 8'h01, "R10 date");
      expect_reg(5, 8'h01, "R10 month");
      expect_reg(6, 8'h00, "R10 year");
      expect_reg(7, 8'h00, "R10 sq");

      // R1: seconds every DIV ticks, minute carry
      write_reg(3'd0, 8'h58);
      run_ticks(DIV);
      expect_reg(0, 8'h59, "R1 second step");
      run_ticks(DIV);
      expect_reg(0, 8'h00, "R1 seconds wrap");
      expect_reg(1, 8'h01, "R1 minute carry");

      // R9: prescaler restart on seconds write, square-wave phase
      run_ticks(DIV - 1);
      write_reg(3'd0, 8'h10);
      expect_reg(7, 8'h00, "R9 sq low after write");
      run_ticks(DIV / 2);
      expect_reg(7, 8'h01, "R9 sq high at half");
      run_ticks(DIV / 2 - 1);
      expect_reg(0, 8'h10, "R9 no step before full count");
      run_ticks(1);
      expect_reg(0, 8'h11, "R9 step at full count");
      expect_reg(7, 8'h00, "R9 sq low at step");

      // R2 R6 R5: 24-hour midnight with year and century wrap
      set_all(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
      run_ticks(DIV);
      expect_reg(2, 8'h00, "R2 hour 23 wraps");
      expect_reg(3, 8'h01, "R6 dow 7 wraps to 1");
      expect_reg(4, 8'h01, "R4 date wraps");
      expect_reg(5, 8'h81, "R5 century set, month 01");
      expect_reg(6, 8'h00, "R5 year wraps");

      // R5: month 12 advances year, century toggles back
      set_all(8'h59, 8'h59, 8'h23, 8'h02, 8'h31, 8'h12, 8'h23);
      run_ticks(DIV);
      expect_reg(5, 8'h01, "R5 month wraps");
      expect_reg(6, 8'h24, "R5 year advances");
      set_all(8'h59, 8'h59, 8'h23, 8'h02, 8'h31, 8'h92, 8'h99);
      run_ticks(DIV);
      expect_reg(5, 8'h01, "R5 century cleared");

      // R3: 12-hour form
      set_all(8'h59, 8'h59, 8'h51, 8'h03, 8'h05, 8'h03, 8'h24);
      run_ticks(DIV);
      expect_reg(2, 8'h72, "R3 AM 11 to PM 12");
      set_all(8'h59, 8'h59, 8'h72, 8'h03, 8'h05, 8'h03, 8'h24);
      run_ticks(DIV);
      expect_reg(2, 8'h61, "R3 PM 12 to PM 1");
      set_all(8'h59, 8'h59, 8'h49, 8'h03, 8'h05, 8'h03, 8'h24);
      run_ticks(DIV);
      expect_reg(2, 8'h50, "R3 AM 9 to AM 10");
      set_all(8'h59, 8'h59, 8'h71, 8'h03, 8'h05, 8'h03, 8'h24);
      run_ticks(DIV);
      expect_reg(2, 8'h52, "R3 PM 11 to AM 12");
      expect_reg(3, 8'h04, "R6 dow advance at 12h midnight");
      expect_reg(4, 8'h06, "R3 date advance at 12h midnight");

      // R4: month lengths
      set_all(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h04, 8'h23);
      run_ticks(DIV);
      expect_reg(4, 8'h01, "R4 April 30 wraps");
      expect_reg(5, 8'h05, "R4 April to May");
      set_all(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h23);
      run_ticks(DIV);
      expect_reg(5, 8'h03, "R4 Feb 28 common year");
      set_all(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h24);
      run_ticks(DIV);
      expect_reg(4, 8'h29, "R4 Feb 29 leap year");
      write_reg(3'd0, 8'h59);
      write_reg(3'd1, 8'h59);
      write_reg(3'd2, 8'h23);
      write_reg(3'd0, 8'h59);
      run_ticks(DIV);
      expect_reg(5, 8'h03, "R4 Feb 29 to March");
      set_all(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h01, 8'h23);
      run_ticks(DIV);
      expect_reg(4, 8'h31, "R4 January has 31");
      set_all(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h11, 8'h23);
      run_ticks(DIV);
      expect_reg(5, 8'h12, "R4 November 30 to December");

      // R7: write beats a concurrent carry, code 7 ignored
      set_all(8'h59, 8'h10, 8'h05, 8'h02, 8'h10, 8'h06, 8'h30);
      run_ticks(DIV - 1);
      @(negedge clk);
      tick_en = 1'b1; wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'h30;
      @(negedge clk);
      tick_en = 1'b0; wr_en = 1'b0;
      expect_reg(0, 8'h00, "R7 seconds stepped");
      expect_reg(1, 8'h30, "R7 write wins over carry");
      expect_reg(2, 8'h05, "R7 no carry into hours");
      write_reg(3'd7, 8'hFF);
      expect_reg(0, 8'h00, "R7 code 7 seconds");
      expect_reg(1, 8'h30, "R7 code 7 minutes");
      expect_reg(2, 8'h05, "R7 code 7 hours");
      expect_reg(3, 8'h02, "R7 code 7 dow");
      expect_reg(4, 8'h10, "R7 code 7 date");
      expect_reg(5, 8'h06, "R7 code 7 month");
      expect_reg(6, 8'h30, "R7 code 7 year");

      // R8: zero-defined bits stay zero
      write_reg(3'd3, 8'hFF);
      expect_reg(3, 8'h07, "R8 dow mask");
      write_reg(3'd5, 8'hFF);
      expect_reg(5, 8'h9F, "R8 month mask");
      write_reg(3'd4, 8'hFF);
      expect_reg(4, 8'h3F, "R8 date mask");
      write_reg(3'd0, 8'hFF);
      expect_reg(0, 8'h7F, "R8 seconds mask");
      write_reg(3'd2, 8'hFF);
      expect_reg(2, 8'h7F, "R8 hours mask");

      @(negedge clk);
      done = 1'b1;
      report();
   end
endmodule